// File: doc/BRIEF.md
# Multiplexed Receive Bus Serializer

This block places the received frames of several line links onto one shared serial system bus. It has a data line and a signaling line, and it follows a bus clock and a frame pulse that come from the system side. Every link has its own channel offset, counted in 8-bit slots, and its own bit offset, counted in bit times. Both are measured from the frame pulse, so each link lands in its own positions on the bus. The bus frame holds 1024 bit times, which is 128 slots.

The bus clock is oversampled by the core clock `clk`. Configuration bits pick the bus-clock edge that samples the frame pulse and the edge that launches output bits. In double-rate mode the bus clock runs at twice the bit rate, and a further bit picks which of the two launch edges in each bit period updates the outputs. The bytes and signaling nibbles come from a combinational read port. The block drives the link and channel address of the bit it is about to launch and takes the returned byte and nibble at the launch.

Top module: `mrx_bus_ser`

## Requirements
- R1: After reset, and until the first frame pulse has been accepted, the data line is 1 and the signaling line is 0.
- R2: A frame pulse is accepted when `fp_i` is high at a sample edge. The first launch edge strictly after that sample edge launches bus bit time 0. This holds whether the sample and launch polarities are equal or differ.
- R3: Link l, channel c, bit b (b = 0 is the MSB of the byte) appears at bus bit time (8*(4*c + chan_off[l]) + bit_off[l] + b) mod 1024. Channels are interleaved across the 4 links.
- R4: The signaling line carries the link's nibble, MSB first, during bits 4 to 7 of each channel. It is 0 during bits 0 to 3.
- R5: In a bit time that no link owns, the data line is 1 and the signaling line is 0. When several links claim one bit time, the lowest-numbered link wins.
- R6: `cfg_fe` = 1 samples the frame pulse on rising bus-clock edges, and 0 samples it on falling edges. `cfg_de` picks the launch polarity in the same way.
- R7: With `cfg_dbl` = 1 a bit lasts two bus-clock cycles. After an accepted pulse, the launch-polarity edges are numbered 0, 1, 0, 1 and so on. Only edges whose number equals `cfg_upd` launch a bit.
- R8: Without a new pulse, the bit counter wraps from 1023 to 0 and the frame repeats.
- R9: Changes to offsets, edge selects and rate mode take effect only at the next accepted frame pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock that oversamples the bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_ck | input | 1 | System bus clock level |
| fp_i | input | 1 | Frame pulse, active high |
| cfg_fe | input | 1 | Sample edge of the frame pulse (1 = rising) |
| cfg_de | input | 1 | Launch edge of the outputs (1 = rising) |
| cfg_dbl | input | 1 | Bus clock at twice the bit rate |
| cfg_upd | input | 1 | Launch edge within the bit in double-rate mode |
| chan_off | input | 28 | Channel offset per link, 7 bits each, link 0 in the low bits |
| bit_off | input | 12 | Bit offset per link, 3 bits each |
| rd_link | output | 2 | Link of the bit being launched |
| rd_chan | output | 5 | Channel of the bit being launched |
| rd_byte | input | 8 | Channel byte for the addressed link and channel |
| rd_nib | input | 4 | Signaling nibble for the addressed link and channel |
| sd_o | output | 1 | Serial data line |
| ss_o | output | 1 | Serial signaling line |

## Verification
Each bus-clock edge is registered in the core cycle that first sees it. An edge that launches a bit therefore shows on `sd_o` and `ss_o` after one core clock. The bench drives each edge on a falling core-clock edge and compares the outputs on the next falling core-clock edge. The outputs are compared again after every edge that does not launch a bit, to confirm that they held. The bench keeps its own record of the accepted pulse, the phase and the bit counter, computed from the edges it generates. It derives each expected bit by searching the channel start positions forward, not by inverting the mapping.

// File: rtl/mrx_pkg.sv
package mrx_pkg;

  localparam int BYTE_W = 8;
  localparam int NIB_W  = 4;
  localparam int BOFF_W = 3;

  typedef struct packed {
    logic fe;   // pulse sample polarity, 1 = rising
    logic de;   // launch polarity, 1 = rising
    logic dbl;  // bus clock at twice the bit rate
    logic upd;  // launch edge index within a double-rate bit
  } edge_cfg_t;

  // Position of bus bit time t inside a link's own stream, modulo fb.
  function automatic int unsigned rel_pos(input int unsigned t,
                                          input int unsigned co,
                                          input int unsigned bo,
                                          input int unsigned fb);
    return (t + 2 * fb - BYTE_W * co - bo) % fb;
  endfunction

endpackage

// File: rtl/mrx_edge_tick.sv
module mrx_edge_tick
  import mrx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      bus_ck,
  input  logic      fp_i,
  input  edge_cfg_t ecfg,
  output logic      sync_o,
  output logic      tick_o,
  output logic      phase_o
);

  logic ck_q;
  logic rise_ev;
  logic fall_ev;
  logic samp_ev;
  logic lnch_ev;

  assign rise_ev = bus_ck & ~ck_q;
  assign fall_ev = ~bus_ck & ck_q;
  assign samp_ev = ecfg.fe ? rise_ev : fall_ev;
  assign lnch_ev = ecfg.de ? rise_ev : fall_ev;

  assign sync_o = samp_ev & fp_i;
  assign tick_o = lnch_ev & (~ecfg.dbl | (phase_o == ecfg.upd));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ck_q    <= 1'b0;
      phase_o <= 1'b0;
    end else begin
      ck_q <= bus_ck;
      if (sync_o) begin
        phase_o <= 1'b0;
      end else if (lnch_ev && ecfg.dbl) begin
        phase_o <= ~phase_o;
      end
    end
  end

endmodule

// File: rtl/mrx_frame_ctr.sv
module mrx_frame_ctr
  import mrx_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int SLOTS     = 128,
  localparam int FB       = SLOTS * BYTE_W,
  localparam int TW       = $clog2(FB),
  localparam int SW       = $clog2(SLOTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sync,
  input  logic                      tick,
  input  logic [NUM_LINKS*SW-1:0]   co_i,
  input  logic [NUM_LINKS*BOFF_W-1:0] bo_i,
  input  edge_cfg_t                 ecfg_i,
  output logic [NUM_LINKS*SW-1:0]   sh_co,
  output logic [NUM_LINKS*BOFF_W-1:0] sh_bo,
  output edge_cfg_t                 sh_ecfg,
  output logic [TW-1:0]             bit_cnt,
  output logic [TW-1:0]             nxt_cnt,
  output logic                      pend,
  output logic                      locked,
  output logic                      launch_valid
);

  logic shadow_load;

  assign launch_valid = pend | locked;
  assign shadow_load  = sync | (~locked & ~pend);
  assign nxt_cnt      = pend ? '0 : ((bit_cnt == TW'(FB - 1)) ? '0 : bit_cnt + 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt <= '0;
      pend    <= 1'b0;
      locked  <= 1'b0;
      sh_co   <= '0;
      sh_bo   <= '0;
      sh_ecfg <= '0;
    end else begin
      if (shadow_load) begin
        sh_co   <= co_i;
        sh_bo   <= bo_i;
        sh_ecfg <= ecfg_i;
      end
      if (tick && launch_valid) begin
        bit_cnt <= nxt_cnt;
      end
      if (tick && pend) begin
        locked <= 1'b1;
      end
      if (sync) begin
        pend <= 1'b1;
      end else if (tick) begin
        pend <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/mrx_slot_map.sv
module mrx_slot_map
  import mrx_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int SLOTS     = 128,
  localparam int FB       = SLOTS * BYTE_W,
  localparam int TW       = $clog2(FB),
  localparam int SW       = $clog2(SLOTS),
  localparam int LW       = $clog2(NUM_LINKS),
  localparam int CW       = $clog2(SLOTS / NUM_LINKS)
) (
  input  logic [TW-1:0]               t_i,
  input  logic [NUM_LINKS*SW-1:0]     co_i,
  input  logic [NUM_LINKS*BOFF_W-1:0] bo_i,
  output logic                        hit_o,
  output logic [LW-1:0]               link_o,
  output logic [CW-1:0]               chan_o,
  output logic [2:0]                  bpos_o,
  output logic [NUM_LINKS-1:0]        win_o
);

  logic [NUM_LINKS-1:0] own;
  logic [CW-1:0]        lch  [NUM_LINKS];
  logic [2:0]           lbit [NUM_LINKS];

  for (genvar l = 0; l < NUM_LINKS; l++) begin : g_link
    logic [TW-1:0] rel;
    assign rel     = TW'(rel_pos(int'(t_i), int'(co_i[l*SW +: SW]),
                                 int'(bo_i[l*BOFF_W +: BOFF_W]), FB));
    assign own[l]  = (rel[3 +: LW] == '0);
    assign lch[l]  = rel[TW-1 -: CW];
    assign lbit[l] = rel[2:0];
  end

  // lowest-numbered owner is assigned last and wins
  always_comb begin
    hit_o  = 1'b0;
    link_o = '0;
    chan_o = '0;
    bpos_o = '0;
    win_o  = '0;
    for (int l = NUM_LINKS - 1; l >= 0; l--) begin
      if (own[l]) begin
        hit_o    = 1'b1;
        link_o   = LW'(l);
        chan_o   = lch[l];
        bpos_o   = lbit[l];
        win_o    = '0;
        win_o[l] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/mrx_bus_ser.sv
module mrx_bus_ser
  import mrx_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int SLOTS     = 128,
  localparam int FB       = SLOTS * BYTE_W,
  localparam int TW       = $clog2(FB),
  localparam int SW       = $clog2(SLOTS),
  localparam int LW       = $clog2(NUM_LINKS),
  localparam int CW       = $clog2(SLOTS / NUM_LINKS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        bus_ck,
  input  logic                        fp_i,
  input  logic                        cfg_fe,
  input  logic                        cfg_de,
  input  logic                        cfg_dbl,
  input  logic                        cfg_upd,
  input  logic [NUM_LINKS*SW-1:0]     chan_off,
  input  logic [NUM_LINKS*BOFF_W-1:0] bit_off,
  output logic [LW-1:0]               rd_link,
  output logic [CW-1:0]               rd_chan,
  input  logic [BYTE_W-1:0]           rd_byte,
  input  logic [NIB_W-1:0]            rd_nib,
  output logic                        sd_o,
  output logic                        ss_o
);

  edge_cfg_t                 raw_ecfg;
  edge_cfg_t                 sh_ecfg;
  logic [NUM_LINKS*SW-1:0]   sh_co;
  logic [NUM_LINKS*BOFF_W-1:0] sh_bo;
  logic                      sync;
  logic                      tick;
  logic                      phase;
  logic [TW-1:0]             bit_cnt;
  logic [TW-1:0]             nxt_cnt;
  logic                      pend;
  logic                      locked;
  logic                      launch_valid;
  logic                      hit;
  logic [2:0]                bpos;
  logic [NUM_LINKS-1:0]      win;
  logic [2:0]                obit_q;

  assign raw_ecfg = '{fe: cfg_fe, de: cfg_de, dbl: cfg_dbl, upd: cfg_upd};

  mrx_edge_tick u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_ck  (bus_ck),
    .fp_i    (fp_i),
    .ecfg    (sh_ecfg),
    .sync_o  (sync),
    .tick_o  (tick),
    .phase_o (phase)
  );

  mrx_frame_ctr #(.NUM_LINKS(NUM_LINKS), .SLOTS(SLOTS)) u_frame (
    .clk          (clk),
    .rst_n        (rst_n),
    .sync         (sync),
    .tick         (tick),
    .co_i         (chan_off),
    .bo_i         (bit_off),
    .ecfg_i       (raw_ecfg),
    .sh_co        (sh_co),
    .sh_bo        (sh_bo),
    .sh_ecfg      (sh_ecfg),
    .bit_cnt      (bit_cnt),
    .nxt_cnt      (nxt_cnt),
    .pend         (pend),
    .locked       (locked),
    .launch_valid (launch_valid)
  );

  mrx_slot_map #(.NUM_LINKS(NUM_LINKS), .SLOTS(SLOTS)) u_map (
    .t_i    (nxt_cnt),
    .co_i   (sh_co),
    .bo_i   (sh_bo),
    .hit_o  (hit),
    .link_o (rd_link),
    .chan_o (rd_chan),
    .bpos_o (bpos),
    .win_o  (win)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sd_o   <= 1'b1;
      ss_o   <= 1'b0;
      obit_q <= '0;
    end else if (tick) begin
      if (launch_valid && hit) begin
        sd_o   <= rd_byte[~bpos];
        ss_o   <= bpos[2] & rd_nib[~bpos[1:0]];
        obit_q <= bpos;
      end else begin
        sd_o   <= 1'b1;
        ss_o   <= 1'b0;
        obit_q <= '0;
      end
    end
  end

endmodule

// File: rtl/mrx_bus_ser_chk.sv
module mrx_bus_ser_chk #(
  parameter int TW = 10,
  parameter int NL = 4,
  parameter int COW = 28
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick,
  input logic           sync,
  input logic           pend,
  input logic           locked,
  input logic           phase,
  input logic [TW-1:0]  bit_cnt,
  input logic           sd_o,
  input logic           ss_o,
  input logic [2:0]     obit_q,
  input logic [NL-1:0]  win,
  input logic [COW-1:0] sh_co
);

  // R1
  idle_before_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !pend) |-> (sd_o && !ss_o));

  // R2
  first_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pend) |=> (locked && bit_cnt == '0));

  // R8
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && locked && !pend && (&bit_cnt)) |=> (bit_cnt == '0));

  // R5
  single_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win));

  // R4
  sig_upper_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ss_o |-> obit_q[2]);

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !sync) |=> $stable(sh_co));

  // R7
  dbl_phase_known_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> !phase);

endmodule

bind mrx_bus_ser mrx_bus_ser_chk #(.TW(TW), .NL(NUM_LINKS), .COW(NUM_LINKS*SW)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .sync    (sync),
  .pend    (pend),
  .locked  (locked),
  .phase   (phase),
  .bit_cnt (bit_cnt),
  .sd_o    (sd_o),
  .ss_o    (ss_o),
  .obit_q  (obit_q),
  .win     (win),
  .sh_co   (sh_co)
);

// File: tb/mrx_bus_ser_tb.sv
module mrx_bus_ser_tb;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int NL         = 4;
  localparam int FBITS      = 1024;
  localparam int NCH        = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_ck = 1'b0;
  logic        fp_i = 1'b0;
  logic        cfg_fe, cfg_de, cfg_dbl, cfg_upd;
  logic [27:0] chan_off;
  logic [11:0] bit_off;
  logic [1:0]  rd_link;
  logic [4:0]  rd_chan;
  logic [7:0]  rd_byte;
  logic [3:0]  rd_nib;
  logic        sd_o, ss_o;

  int in_co [NL];
  int in_bo [NL];
  int seed = 3;
  int n_chk = 0;
  int n_err = 0;

  // bench model state
  logic m_fe, m_de, m_dbl, m_upd, m_phase, m_pend, m_lock;
  int   m_co [NL];
  int   m_bo [NL];
  int   m_cnt;
  logic e_sd, e_ss;

  always #(CLK_PERIOD/2) clk = ~clk;

  mrx_bus_ser u_dut (
    .clk(clk), .rst_n(rst_n), .bus_ck(bus_ck), .fp_i(fp_i),
    .cfg_fe(cfg_fe), .cfg_de(cfg_de), .cfg_dbl(cfg_dbl), .cfg_upd(cfg_upd),
    .chan_off(chan_off), .bit_off(bit_off),
    .rd_link(rd_link), .rd_chan(rd_chan), .rd_byte(rd_byte), .rd_nib(rd_nib),
    .sd_o(sd_o), .ss_o(ss_o)
  );

  function automatic logic [7:0] mem_byte(input int l, input int c);
    return 8'(l * 53 + c * 29 + seed * 7 + 5);
  endfunction

  function automatic logic [3:0] mem_nib(input int l, input int c);
    return 4'(l * 5 + c * 3 + seed);
  endfunction

  always_comb begin
    for (int l = 0; l < NL; l++) begin
      chan_off[l*7 +: 7] = 7'(in_co[l]);
      bit_off[l*3 +: 3]  = 3'(in_bo[l]);
    end
    rd_byte = mem_byte(int'(rd_link), int'(rd_chan));
    rd_nib  = mem_nib(int'(rd_link), int'(rd_chan));
  end

  task automatic load_shadow();
    m_fe = cfg_fe; m_de = cfg_de; m_dbl = cfg_dbl; m_upd = cfg_upd;
    for (int l = 0; l < NL; l++) begin
      m_co[l] = in_co[l];
      m_bo[l] = in_bo[l];
    end
  endtask

  // forward search over channel start positions
  task automatic exp_bit(input int nt, output logic sd, output logic ss);
    bit found = 0;
    sd = 1'b1; ss = 1'b0;
    for (int l = 0; l < NL && !found; l++) begin
      for (int c = 0; c < NCH && !found; c++) begin
        int st  = (8 * (c * NL + m_co[l]) + m_bo[l]) % FBITS;
        int off = (nt - st + FBITS) % FBITS;
        if (off < 8) begin
          logic [7:0] by = mem_byte(l, c);
          logic [3:0] nb = mem_nib(l, c);
          found = 1;
          sd = by[7 - off];
          ss = (off >= 4) ? nb[7 - off] : 1'b0;
        end
      end
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (sd_o !== e_sd || ss_o !== e_ss) begin
      n_err++;
      $display("FAIL %s: bit %0d sd=%b ss=%b expected sd=%b ss=%b",
               tag, m_cnt, sd_o, ss_o, e_sd, e_ss);
    end
  endtask

  task automatic drive_edge(input logic lvl, input logic pulse, input string tag);
    logic smp, lch, tk;
    @(negedge clk);
    bus_ck = lvl;
    fp_i   = pulse;
    if (!m_lock && !m_pend) load_shadow();
    smp = (lvl == m_fe);
    lch = (lvl == m_de);
    tk  = lch && (!m_dbl || m_phase == m_upd);
    if (tk) begin
      if (m_pend || m_lock) begin
        m_cnt = m_pend ? 0 : (m_cnt + 1) % FBITS;
        exp_bit(m_cnt, e_sd, e_ss);
        if (m_pend) m_lock = 1'b1;
      end else begin
        e_sd = 1'b1; e_ss = 1'b0;
      end
    end
    if (smp && pulse) m_phase = 1'b0;
    else if (lch && m_dbl) m_phase = ~m_phase;
    if (smp && pulse) begin
      m_pend = 1'b1;
      load_shadow();
    end else if (tk) begin
      m_pend = 1'b0;
    end
    @(negedge clk);
    check(tag);
    repeat (HALF - 2) @(negedge clk);
  endtask

  // one bus-clock cycle per k; pulses on the sample edge of cycles p1/p2
  task automatic run_bus(input string tag, input int ncyc, input int p1,
                         input int p2, input int chg);
    for (int k = 0; k < ncyc; k++) begin
      bit pk = (k == p1) || (k == p2);
      if (k == chg) begin
        in_co = '{9, 2, 7, 4};
        in_bo = '{6, 1, 0, 5};
      end
      drive_edge(1'b1, pk && (m_fe == 1'b1), tag);
      drive_edge(1'b0, pk && (m_fe == 1'b0), tag);
    end
  endtask

  task automatic set_cfg(input logic fe, input logic de, input logic dbl,
                         input logic upd);
    cfg_fe = fe; cfg_de = de; cfg_dbl = dbl; cfg_upd = upd;
  endtask

  task automatic t_reset();
    // R1: idle lines after reset and before any pulse
    e_sd = 1'b1; e_ss = 1'b0; m_cnt = 0;
    @(negedge clk);
    check("R1");
    run_bus("R1", 20, -1, -1, -1);
  endtask

  task automatic t_basic();
    // R3, R4, R8: aligned links, full frame plus wrap
    in_co = '{0, 1, 2, 3};
    in_bo = '{0, 0, 0, 0};
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
    run_bus("R3/R4/R8", 1100, 2, -1, -1);
  endtask

  task automatic t_edges();
    // R2, R6: sample and launch polarities differ both ways
    set_cfg(1'b0, 1'b1, 1'b0, 1'b0);
    run_bus("R2/R6", 300, 3, -1, -1);
    set_cfg(1'b1, 1'b0, 1'b0, 1'b0);
    run_bus("R2/R6", 300, 3, -1, -1);
    set_cfg(1'b0, 1'b0, 1'b0, 1'b0);
    run_bus("R2/R6", 300, 3, -1, -1);
  endtask

  task automatic t_double();
    // R7: double-rate clock with either launch edge of the bit
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0);
    run_bus("R7", 300, 3, -1, -1);
    set_cfg(1'b1, 1'b0, 1'b1, 1'b1);
    run_bus("R7", 300, 3, -1, -1);
  endtask

  task automatic t_offsets();
    // R5, R3, R8: collisions, empty slots, bit offsets wrapping the frame
    seed  = 11;
    in_co = '{5, 5, 2, 127};
    in_bo = '{3, 0, 7, 1};
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
    run_bus("R5/R3/R8", 1100, 2, -1, -1);
  endtask

  task automatic t_reconf();
    // R9: offsets changed mid-frame act only after the next pulse
    in_co = '{0, 1, 2, 3};
    in_bo = '{0, 0, 0, 0};
    run_bus("R9", 800, 2, 500, 200);
  endtask

  initial begin
    in_co = '{0, 1, 2, 3};
    in_bo = '{0, 0, 0, 0};
    set_cfg(1'b1, 1'b1, 1'b0, 1'b0);
    m_phase = 1'b0; m_pend = 1'b0; m_lock = 1'b0;
    load_shadow();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_edges();
    t_double();
    t_offsets();
    t_reconf();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R1: watchdog expired, actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule